// File: doc/BRIEF.md
# Per-Element Power-of-Two Log Router

This block moves data words around a ring of lanes; the lane count is a power of two, eight by default. A word enters on its source lane with a destination lane number. On entry the block computes the cyclic distance `(dest - src) mod LANES` and stores it as the word's remaining route. Each routing cycle, the word at the head of a lane queue hops forward by the largest power of two still set in its remaining route, and that bit is cleared. A word moves independently of the others, by a distance of its own. When the remaining route reaches zero, the word waits on its lane's output for a valid/ready handshake.

Every lane owns a small queue, because words from several lanes can land on the same lane. Each word carries an age: the cycle in which it was accepted, with the lower origin lane treated as older when two ages are equal. The head of a queue is always its oldest word. When more heads aim at a lane than it has free slots, the oldest heads win. Slots freed by output removal in the current cycle count as free. New entries from the lane input have the lowest priority, after the hops.

Top module: `log_router`

## Requirements
- R1: Every accepted word leaves exactly once, on the output lane equal to its destination, with its payload unchanged.
- R2: An uncontended word makes one hop per set bit of `(dest - src) mod LANES`, largest first. Its output valid rises after one clock edge past the accepting edge for each set bit; with distance zero, it rises right after the accepting edge.
- R3: `in_ready` of a lane is low while that lane's queue holds DEPTH words and its head does not leave through the output in that cycle. A head leaving through the output frees its slot in the same cycle.
- R4: Within one lane queue the oldest word leaves first. Age is the acceptance cycle, and for equal ages the word from the lower-numbered origin lane is older, even if it arrived in the queue later.
- R5: When more heads target a lane than it has free slots, the oldest heads are moved. A losing head stays at the head of its own queue and retries in the next cycle.
- R6: Once a word is presented with `out_valid` high and `out_ready` low, the same word with the same data stays presented until it is taken.
- R7: An input word is accepted on a lane only when the lane's free slots outnumber the heads that request a hop into that lane in the same cycle.
- R8: After reset all queues are empty, every `out_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Per-lane input word present |
| in_ready | output | LANES | Per-lane input accepted this cycle when valid |
| in_data | input | LANES x W | Per-lane input payload |
| in_dest | input | LANES x log2(LANES) | Per-lane destination lane number |
| out_valid | output | LANES | Head word of the lane has arrived and is presented |
| out_ready | input | LANES | Consumer takes the presented word |
| out_data | output | LANES x W | Presented payload |

## Verification
Two events can fall on one lane in the same cycle: a head hopping in from another lane, and a new word entering on that lane's input. The same is true of two heads from different lanes hopping into one lane. The bench fills a lane to one free slot with its output stalled. It then times a hop into that lane so that the hop competes either with an input word or with a second hop. The result is judged at the ports: `in_ready` must fall, and the older hopper must win. A word parked behind each competing head shows the winner, because only a lane whose head left starts presenting its next word.

// File: rtl/log_router.sv
module log_router #(
  parameter int LANES = 8,
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int AGEW  = 10,
  localparam int LG   = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          in_valid,
  output logic [LANES-1:0]          in_ready,
  input  logic [LANES-1:0][W-1:0]   in_data,
  input  logic [LANES-1:0][LG-1:0]  in_dest,
  output logic [LANES-1:0]          out_valid,
  input  logic [LANES-1:0]          out_ready,
  output logic [LANES-1:0][W-1:0]   out_data
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(LANES + DEPTH + 1);

  typedef struct packed {
    logic [W-1:0]    pay;
    logic [LG-1:0]   rem;
    logic [AGEW-1:0] age;
    logic [LG-1:0]   org;
  } ent_t;

  ent_t             q    [LANES][DEPTH];
  logic [DEPTH-1:0] v    [LANES];
  logic [LANES-1:0] lk;
  logic [SW-1:0]    lkix [LANES];
  logic [AGEW-1:0]  now;

  ent_t             hd   [LANES];
  logic [SW-1:0]    hix  [LANES];
  logic [LANES-1:0] hv, want, pop, grant, acc;
  logic [LG-1:0]    step [LANES];
  logic [LG-1:0]    tgt  [LANES];
  logic [CW-1:0]    free [LANES];
  logic [CW-1:0]    hin  [LANES];
  logic [CW-1:0]    gin  [LANES];
  logic [CW-1:0]    rank [LANES];
  logic [DEPTH-1:0] fs   [LANES];
  logic [CW-1:0]    fidx [LANES][DEPTH];

  function automatic logic older(input ent_t a, input ent_t b);
    logic [AGEW-1:0] d;
    d = a.age - b.age;
    if (d == '0) return a.org < b.org;
    return d[AGEW-1];
  endfunction

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      hv[j]  = 1'b0;
      hix[j] = '0;
      hd[j]  = q[j][0];
      if (lk[j]) begin
        hv[j]  = 1'b1;
        hix[j] = lkix[j];
        hd[j]  = q[j][lkix[j]];
      end else begin
        for (int k = 0; k < DEPTH; k++)
          if (v[j][k] && (!hv[j] || older(q[j][k], hd[j]))) begin
            hv[j]  = 1'b1;
            hix[j] = SW'(k);
            hd[j]  = q[j][k];
          end
      end
      step[j] = '0;
      for (int b = 0; b < LG; b++)
        if (hd[j].rem[b]) begin
          step[j]    = '0;
          step[j][b] = 1'b1;
        end
      tgt[j]       = LG'(j) + step[j];
      want[j]      = hv[j] && (hd[j].rem != '0);
      out_valid[j] = hv[j] && (hd[j].rem == '0);
      out_data[j]  = hd[j].pay;
      pop[j]       = out_valid[j] && out_ready[j];
      free[j]      = '0;
      for (int k = 0; k < DEPTH; k++) begin
        fs[j][k]   = !v[j][k] || (pop[j] && (hix[j] == SW'(k)));
        fidx[j][k] = free[j];
        free[j]    = free[j] + CW'(fs[j][k]);
      end
    end
    for (int i = 0; i < LANES; i++) begin
      rank[i] = '0;
      for (int k = 0; k < LANES; k++)
        if (k != i && want[k] && tgt[k] == tgt[i] && older(hd[k], hd[i]))
          rank[i] = rank[i] + CW'(1);
      grant[i] = want[i] && (rank[i] < free[tgt[i]]);
    end
    for (int j = 0; j < LANES; j++) begin
      hin[j] = '0;
      gin[j] = '0;
      for (int i = 0; i < LANES; i++)
        if (want[i] && tgt[i] == LG'(j)) begin
          hin[j] = hin[j] + CW'(1);
          if (grant[i]) gin[j] = gin[j] + CW'(1);
        end
      in_ready[j] = hin[j] < free[j];
      acc[j]      = in_valid[j] && in_ready[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= '0;
      lk  <= '0;
      for (int j = 0; j < LANES; j++) begin
        v[j]    <= '0;
        lkix[j] <= '0;
      end
    end else begin
      now <= now + AGEW'(1);
      for (int j = 0; j < LANES; j++) begin
        lk[j]   <= out_valid[j] && !out_ready[j];
        lkix[j] <= hix[j];
        if (pop[j] || grant[j]) v[j][hix[j]] <= 1'b0;
      end
      for (int j = 0; j < LANES; j++)
        for (int k = 0; k < DEPTH; k++)
          if (fs[j][k]) begin
            for (int i = 0; i < LANES; i++)
              if (grant[i] && tgt[i] == LG'(j) && rank[i] == fidx[j][k]) begin
                v[j][k] <= 1'b1;
                q[j][k] <= '{pay: hd[i].pay, rem: hd[i].rem & ~step[i],
                             age: hd[i].age, org: hd[i].org};
              end
            if (acc[j] && hin[j] == fidx[j][k]) begin
              v[j][k] <= 1'b1;
              q[j][k] <= '{pay: in_data[j], rem: in_dest[j] - LG'(j),
                           age: now, org: LG'(j)};
            end
          end
    end
  end

  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0 && in_ready == '1));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((&v[j]) && !pop[j]) |-> !in_ready[j]);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && !out_ready[j]) |=> (out_valid[j] && $stable(out_data[j])));
    p_grant_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gin[j] + CW'(acc[j])) <= free[j]);
  end
endmodule

// File: tb/log_router_tb.sv
`timescale 1ns/1ps
module log_router_tb;
  localparam int L = 8, W = 16, LG = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0] in_valid, in_ready, out_valid, out_ready;
  logic [L-1:0][W-1:0] in_data, out_data;
  logic [L-1:0][LG-1:0] in_dest;

  log_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dest(in_dest), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, next_id = 0, n_acc = 0, n_del = 0;
  logic [LG-1:0] dst [4096];
  int tin [4096];
  bit accd [4096], done [4096];
  logic [15:0] lg [L][64];
  int lgc [L];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int id;
    bit ok;
    if (rst_n)
      for (int l = 0; l < L; l++)
        if (out_valid[l] && out_ready[l]) begin
          id = int'(out_data[l]);
          ok = id < next_id && accd[id] && !done[id] && dst[id] == LG'(l);
          chk(ok, "R1 delivery lane/once", id, l);
          if (ok) begin
            done[id] = 1;
            n_del++;
            chk(cyc - tin[id] <= 100, "R1 bounded latency", cyc - tin[id], 100);
          end
          lg[l][lgc[l] % 64] = out_data[l];
          lgc[l]++;
        end
  end

  task automatic drive(input logic [L-1:0] m, input logic [L-1:0][LG-1:0] d);
    for (int l = 0; l < L; l++) begin
      in_data[l] = W'(next_id);
      if (m[l]) begin
        dst[next_id] = d[l];
        next_id++;
      end
    end
    in_dest = d;
    in_valid = m;
    @(negedge clk);
    for (int l = 0; l < L; l++)
      if (m[l] && in_ready[l]) begin
        accd[in_data[l]] = 1;
        tin[in_data[l]] = cyc;
        n_acc++;
      end
    @(posedge clk); #1;
    in_valid = '0;
  endtask

  task automatic drive1(input int s, input int d);
    logic [L-1:0][LG-1:0] dd;
    dd = '0;
    dd[s] = LG'(d);
    drive(L'(1) << s, dd);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic t_latency;
    out_ready = '1;
    for (int s = 0; s < L; s++)
      for (int r = 0; r < L; r++) begin
        int d, n;
        d = (s + r) % L;
        n = 0;
        drive1(s, d);
        do begin @(negedge clk); n++; end while (!out_valid[d] && n < 12);
        chk(n == $countones(r) + 1, "R2 hop count latency", n, $countones(r) + 1);
        @(posedge clk); #1;
      end
  endtask

  task automatic t_order;
    int x, base;
    logic [L-1:0][LG-1:0] dd;
    out_ready = 8'hFF & ~8'h20;
    base = lgc[5];
    x = next_id;
    drive1(7, 5);
    dd = '0; dd[1] = 3'd5; dd[3] = 3'd5;
    drive(8'h0A, dd);
    drive1(5, 5);
    idle(4);
    @(negedge clk);
    chk(out_valid[5] && out_data[5] == W'(x), "R6 presented while stalled", int'(out_data[5]), x);
    @(negedge clk);
    chk(out_valid[5] && out_data[5] == W'(x), "R6 stable while stalled", int'(out_data[5]), x);
    @(posedge clk); #1;
    out_ready = '1;
    idle(8);
    chk(lg[5][base % 64] == W'(x), "R4 oldest first", int'(lg[5][base % 64]), x);
    chk(lg[5][(base + 1) % 64] == W'(x + 1), "R4 tie lower origin", int'(lg[5][(base + 1) % 64]), x + 1);
    chk(lg[5][(base + 2) % 64] == W'(x + 2), "R4 late arrival older", int'(lg[5][(base + 2) % 64]), x + 2);
    chk(lg[5][(base + 3) % 64] == W'(x + 3), "R4 youngest last", int'(lg[5][(base + 3) % 64]), x + 3);
  endtask

  task automatic t_conflict;
    int x, p, y, q, base;
    logic [L-1:0][LG-1:0] dd;
    out_ready = 8'hFF & ~8'h40;
    base = lgc[6];
    repeat (3) drive1(6, 6);
    x = next_id;
    drive1(0, 6);
    p = next_id; y = p + 1;
    dd = '0; dd[4] = 3'd4; dd[5] = 3'd6;
    drive(8'h30, dd);
    q = next_id;
    drive1(5, 5);
    @(negedge clk);
    chk(out_valid[4] && out_data[4] == W'(p), "R5 older head moved", int'(out_valid[4]), 1);
    chk(!out_valid[5], "R5 younger head held", int'(out_valid[5]), 0);
    @(posedge clk); #1;
    out_ready = '1;
    idle(12);
    chk(lg[6][(base + 3) % 64] == W'(x), "R5 winner order", int'(lg[6][(base + 3) % 64]), x);
    chk(lg[6][(base + 4) % 64] == W'(y), "R5 loser retried", int'(lg[6][(base + 4) % 64]), y);
    chk(done[q], "R5 queued word behind loser", int'(done[q]), 1);
  endtask

  task automatic t_inject;
    out_ready = 8'hFF & ~8'h10;
    repeat (3) drive1(4, 4);
    drive1(3, 4);
    @(negedge clk);
    chk(!in_ready[4], "R7 hop beats input", int'(in_ready[4]), 0);
    chk(in_ready[3], "R7 other lane open", int'(in_ready[3]), 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(!in_ready[4], "R3 full lane blocks", int'(in_ready[4]), 0);
    @(posedge clk); #1;
    out_ready = '1;
    @(negedge clk);
    chk(in_ready[4], "R3 pop frees slot", int'(in_ready[4]), 1);
    @(posedge clk); #1;
    idle(10);
  endtask

  task automatic t_random;
    for (int it = 0; it < 300; it++) begin
      logic [L-1:0] m;
      logic [L-1:0][LG-1:0] dd;
      int cnt;
      out_ready = L'($urandom);
      m = '0; cnt = 0;
      for (int l = 0; l < L; l++) begin
        dd[l] = LG'($urandom);
        if ($urandom % 3 == 0 && (n_acc - n_del + cnt) < 7) begin
          m[l] = 1'b1;
          cnt++;
        end
      end
      drive(m, dd);
    end
    out_ready = '1;
    idle(80);
    chk(n_del == n_acc, "R1 all delivered", n_del, n_acc);
  endtask

  initial begin
    in_valid = '0; in_data = '0; in_dest = '0; out_ready = '1;
    for (int l = 0; l < L; l++) lgc[l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R8 reset out_valid", int'(out_valid), 0);
    chk(in_ready == '1, "R8 reset in_ready", int'(in_ready), 255);
    @(posedge clk); #1;
    t_latency;
    t_order;
    t_conflict;
    t_inject;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule